// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six architectural condition flags of an 8-bit processor datapath: carry, zero, interrupt mask, decimal mode, overflow and negative. A control decoder outside the block issues one-hot load commands. Each command names one destination flag and one source. The possible sources are the internal data bus, the ALU carry and overflow outputs, the ALU zero detector, bit 5 of the instruction register, a constant, and an external set-overflow pin. A flag changes only on a clock edge where at least one of its own commands is active. Otherwise it keeps its value.

The set-overflow pin comes from outside the clock domain, so it passes through a synchronizer chain before it reaches the overflow flag. While the synchronized level is high, the overflow flag is forced to 1. A read enable packs the flags into a status byte and places it on the internal data bus. While the enable is low the bus output is held at zero, so it can join a wired-OR bus. The break flag, interrupt sequencing and the command decoder are not part of this block.

Top module: `status_flags`

## Requirements
- R1: Synchronous active-high reset sets the interrupt mask to 1 and clears carry, zero, decimal, overflow and negative.
- R2: A bus-load-status command loads three flags together from the data bus on the next edge: zero from bit 1, interrupt mask from bit 2, decimal from bit 3.
- R3: Carry, overflow and negative each have their own bus-load command, taking data-bus bit 0, bit 6 and bit 7 respectively. Each command leaves the other flags alone.
- R4: Separate set/clear commands for the interrupt mask, carry and decimal flags each copy instruction-register bit 5 into their flag.
- R5: An ALU-carry command copies the ALU carry-out into carry, and an ALU-overflow command copies the ALU overflow output into overflow.
- R6: A zero-detect command copies the ALU zero-detect result into the zero flag.
- R7: A clear-overflow command forces overflow to 0.
- R8: The set-overflow pin passes through SYNC_STAGES flip-flops. With the default of 2, a pin level first seen at edge k forces overflow to 1 from edge k+2 onward, for as long as the synchronized level stays high.
- R9: A flag with no active command in a cycle keeps its value, whatever the data, ALU, instruction-bit and command inputs of the other flags do.
- R10: When several commands target one flag in the same cycle, a fixed priority decides. Carry: ALU carry, then instruction bit, then bus. Zero: zero-detect, then bus. Interrupt mask and decimal: instruction bit, then bus. Overflow: synchronized pin, then clear, then ALU overflow, then bus.
- R11: With the read enable high, the bus output carries negative in bit 7, overflow in bit 6, a constant 1 in bit 5, 0 in bit 4, decimal in bit 3, interrupt mask in bit 2, zero in bit 1 and carry in bit 0. With the enable low, the bus output is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_in | input | 8 | Internal data bus value |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| alu_zero | input | 1 | ALU zero-detect result |
| ir_b5 | input | 1 | Instruction register bit 5 |
| so_pin | input | 1 | Asynchronous set-overflow pin |
| ld_bus_izd | input | 1 | Load I, D, Z from the bus |
| ld_bus_c | input | 1 | Load carry from bus bit 0 |
| ld_bus_v | input | 1 | Load overflow from bus bit 6 |
| ld_bus_n | input | 1 | Load negative from bus bit 7 |
| ld_ir_i | input | 1 | Interrupt mask from instruction bit 5 |
| ld_ir_c | input | 1 | Carry from instruction bit 5 |
| ld_ir_d | input | 1 | Decimal from instruction bit 5 |
| ld_alu_c | input | 1 | Carry from ALU carry-out |
| ld_alu_v | input | 1 | Overflow from ALU overflow |
| ld_zero_z | input | 1 | Zero from zero-detect |
| clr_v | input | 1 | Clear overflow |
| rd_status | input | 1 | Place the status byte on the bus output |
| bus_out | output | 8 | Packed status byte, or zero when not read |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_i | output | 1 | Interrupt mask flag |
| flag_d | output | 1 | Decimal mode flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2 and passes the same value to its own latency arithmetic. That makes the exact edge at which the pin first forces overflow observable. It also exposes the window in which the still-high synchronizer output overrides a clear command after the pin has dropped. Every pair of competing commands on one flag is driven with opposite source values, so a priority change shows up as a wrong flag level.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;

    localparam int BYTE_W = 8;

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_I = 2;
    localparam int POS_D = 3;
    localparam int POS_B = 4;
    localparam int POS_K = 5;
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

    function automatic logic [BYTE_W-1:0] pack_status(input flags_t f);
        logic [BYTE_W-1:0] b;
        b        = '0;
        b[POS_C] = f.c;
        b[POS_Z] = f.z;
        b[POS_I] = f.i;
        b[POS_D] = f.d;
        b[POS_B] = 1'b0;
        b[POS_K] = 1'b1;
        b[POS_V] = f.v;
        b[POS_N] = f.n;
        return b;
    endfunction

endpackage

// File: rtl/sf_sync.sv
module sf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sf_flag_cell.sv
module sf_flag_cell #(
    parameter int   N_SRC   = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] sel,
    input  logic [N_SRC-1:0] src,
    output logic             q
);
    logic nxt;

    // index 0 has the highest priority
    always_comb begin
        nxt = q;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (sel[k]) nxt = src[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= nxt;
    end

    // R9: no command, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(|sel) |=> q == $past(q));

    // R10: top-priority source always wins
    p_top_wins_r10: assert property (@(posedge clk) disable iff (rst)
        sel[0] |=> q == $past(src[0]));

endmodule

// File: rtl/sf_status_pack.sv
module sf_status_pack
    import status_flags_pkg::*;
(
    input  flags_t            flags,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] bus
);
    always_comb begin
        bus = rd_en ? pack_status(flags) : '0;
    end

    // R11: fixed bits while reading, quiet bus otherwise
    always_comb begin
        if (rd_en) begin
            a_fixed_bits_r11: assert (bus[POS_K] == 1'b1 && bus[POS_B] == 1'b0);
        end else begin
            a_idle_bus_r11: assert (bus == '0);
        end
    end
endmodule

// File: rtl/status_flags.sv
module status_flags
    import status_flags_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] db_in,
    input  logic       alu_carry,
    input  logic       alu_ovf,
    input  logic       alu_zero,
    input  logic       ir_b5,
    input  logic       so_pin,
    input  logic       ld_bus_izd,
    input  logic       ld_bus_c,
    input  logic       ld_bus_v,
    input  logic       ld_bus_n,
    input  logic       ld_ir_i,
    input  logic       ld_ir_c,
    input  logic       ld_ir_d,
    input  logic       ld_alu_c,
    input  logic       ld_alu_v,
    input  logic       ld_zero_z,
    input  logic       clr_v,
    input  logic       rd_status,
    output logic [7:0] bus_out,
    output logic       flag_c,
    output logic       flag_z,
    output logic       flag_i,
    output logic       flag_d,
    output logic       flag_v,
    output logic       flag_n
);
    localparam int C_SRC = 3;
    localparam int Z_SRC = 2;
    localparam int I_SRC = 2;
    localparam int D_SRC = 2;
    localparam int V_SRC = 4;
    localparam int N_SRC = 1;

    flags_t flags;
    logic   so_s;
    logic   unused_db;

    assign unused_db = ^db_in[POS_K:POS_B];

    sf_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
        .clk(clk), .rst(rst), .d(so_pin), .q(so_s)
    );

    sf_flag_cell #(.N_SRC(C_SRC), .RST_VAL(FLAGS_RESET.c)) u_c (
        .clk(clk), .rst(rst),
        .sel({ld_bus_c,      ld_ir_c, ld_alu_c}),
        .src({db_in[POS_C],  ir_b5,   alu_carry}),
        .q(flags.c)
    );

    sf_flag_cell #(.N_SRC(Z_SRC), .RST_VAL(FLAGS_RESET.z)) u_z (
        .clk(clk), .rst(rst),
        .sel({ld_bus_izd,    ld_zero_z}),
        .src({db_in[POS_Z],  alu_zero}),
        .q(flags.z)
    );

    sf_flag_cell #(.N_SRC(I_SRC), .RST_VAL(FLAGS_RESET.i)) u_i (
        .clk(clk), .rst(rst),
        .sel({ld_bus_izd,    ld_ir_i}),
        .src({db_in[POS_I],  ir_b5}),
        .q(flags.i)
    );

    sf_flag_cell #(.N_SRC(D_SRC), .RST_VAL(FLAGS_RESET.d)) u_d (
        .clk(clk), .rst(rst),
        .sel({ld_bus_izd,    ld_ir_d}),
        .src({db_in[POS_D],  ir_b5}),
        .q(flags.d)
    );

    sf_flag_cell #(.N_SRC(V_SRC), .RST_VAL(FLAGS_RESET.v)) u_v (
        .clk(clk), .rst(rst),
        .sel({ld_bus_v,      ld_alu_v, clr_v, so_s}),
        .src({db_in[POS_V],  alu_ovf,  1'b0,  1'b1}),
        .q(flags.v)
    );

    sf_flag_cell #(.N_SRC(N_SRC), .RST_VAL(FLAGS_RESET.n)) u_n (
        .clk(clk), .rst(rst),
        .sel(ld_bus_n),
        .src(db_in[POS_N]),
        .q(flags.n)
    );

    sf_status_pack u_pack (
        .flags(flags), .rd_en(rd_status), .bus(bus_out)
    );

    assign flag_c = flags.c;
    assign flag_z = flags.z;
    assign flag_i = flags.i;
    assign flag_d = flags.d;
    assign flag_v = flags.v;
    assign flag_n = flags.n;

    // R1: state after reset
    p_reset_val_r1: assert property (@(posedge clk)
        $past(rst) |-> (flag_i && !flag_c && !flag_z && !flag_d && !flag_v && !flag_n));

    // R8: synchronized pin forces overflow
    p_so_force_r8: assert property (@(posedge clk) disable iff (rst)
        so_s |=> flag_v);

    // R7: clear wins when the pin is quiet
    p_clr_v_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_v && !so_s) |=> !flag_v);

    // R5: ALU carry reaches C
    p_alu_carry_r5: assert property (@(posedge clk) disable iff (rst)
        ld_alu_c |=> flag_c == $past(alu_carry));

    // R6: zero detect reaches Z
    p_zero_det_r6: assert property (@(posedge clk) disable iff (rst)
        ld_zero_z |=> flag_z == $past(alu_zero));

    // R11: bus mirrors flags while read
    p_bus_pack_r11: assert property (@(posedge clk) disable iff (rst)
        rd_status |-> (bus_out[POS_N] == flag_n && bus_out[POS_C] == flag_c));

endmodule

// File: tb/test_status_flags.sv
module test_status_flags;
    localparam int PERIOD = 10;
    localparam int SYNC   = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] db_in;
    logic       alu_carry, alu_ovf, alu_zero, ir_b5, so_pin;
    logic       ld_bus_izd, ld_bus_c, ld_bus_v, ld_bus_n;
    logic       ld_ir_i, ld_ir_c, ld_ir_d, ld_alu_c, ld_alu_v, ld_zero_z, clr_v;
    logic       rd_status;
    logic [7:0] bus_out;
    logic       flag_c, flag_z, flag_i, flag_d, flag_v, flag_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    status_flags #(.SYNC_STAGES(SYNC)) i_status_flags (
        .clk(clk), .rst(rst), .db_in(db_in),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
        .ir_b5(ir_b5), .so_pin(so_pin),
        .ld_bus_izd(ld_bus_izd), .ld_bus_c(ld_bus_c), .ld_bus_v(ld_bus_v), .ld_bus_n(ld_bus_n),
        .ld_ir_i(ld_ir_i), .ld_ir_c(ld_ir_c), .ld_ir_d(ld_ir_d),
        .ld_alu_c(ld_alu_c), .ld_alu_v(ld_alu_v), .ld_zero_z(ld_zero_z), .clr_v(clr_v),
        .rd_status(rd_status), .bus_out(bus_out),
        .flag_c(flag_c), .flag_z(flag_z), .flag_i(flag_i),
        .flag_d(flag_d), .flag_v(flag_v), .flag_n(flag_n)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [5:0] fl();
        return {flag_n, flag_v, flag_d, flag_i, flag_z, flag_c};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_bus_izd = 0; ld_bus_c = 0; ld_bus_v = 0; ld_bus_n = 0;
        ld_ir_i = 0; ld_ir_c = 0; ld_ir_d = 0;
        ld_alu_c = 0; ld_alu_v = 0; ld_zero_z = 0; clr_v = 0;
    endtask

    // expected order {n,v,d,i,z,c}
    task automatic chk_flags(input string req, input logic [5:0] exp);
        checks++;
        if (fl() !== exp) begin
            errors++;
            $display("FAIL %s flags nvdizc actual %b expected %b", req, fl(), exp);
        end
    endtask

    task automatic chk_bus(input string req, input logic [7:0] exp);
        checks++;
        if (bus_out !== exp) begin
            errors++;
            $display("FAIL %s bus_out actual %h expected %h", req, bus_out, exp);
        end
    endtask

    task automatic load_all(input logic [5:0] v);
        db_in = {v[5], v[4], 2'b00, v[3], v[2], v[1], v[0]};
        ld_bus_izd = 1; ld_bus_c = 1; ld_bus_v = 1; ld_bus_n = 1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick();
        chk_flags("R1", 6'b000100);
        rd_status = 1; #1;
        chk_bus("R1", 8'h24);
        rd_status = 0;
        rst = 0;
    endtask

    task automatic t_bus_izd();
        db_in = 8'hFF; ld_bus_izd = 1; tick(); idle();
        chk_flags("R2", 6'b001110);
        db_in = 8'h0A; ld_bus_izd = 1; tick(); idle();
        chk_flags("R2", 6'b001010);
    endtask

    task automatic t_bus_cvn();
        load_all(6'b000000);
        db_in = 8'h3E; ld_bus_c = 1; tick(); idle();
        chk_flags("R3", 6'b000000);
        db_in = 8'h01; ld_bus_c = 1; tick(); idle();
        chk_flags("R3", 6'b000001);
        db_in = 8'h40; ld_bus_v = 1; tick(); idle();
        chk_flags("R3", 6'b010001);
        db_in = 8'h80; ld_bus_n = 1; tick(); idle();
        chk_flags("R3", 6'b110001);
    endtask

    task automatic t_ir5();
        load_all(6'b000000);
        ir_b5 = 1; ld_ir_i = 1; tick(); idle();
        chk_flags("R4", 6'b000100);
        ld_ir_c = 1; tick(); idle();
        chk_flags("R4", 6'b000101);
        ld_ir_d = 1; tick(); idle();
        chk_flags("R4", 6'b001101);
        ir_b5 = 0; ld_ir_i = 1; ld_ir_d = 1; tick(); idle();
        chk_flags("R4", 6'b000001);
        ld_ir_c = 1; tick(); idle();
        chk_flags("R4", 6'b000000);
    endtask

    task automatic t_alu();
        load_all(6'b000000);
        alu_carry = 1; ld_alu_c = 1; tick(); idle();
        chk_flags("R5", 6'b000001);
        alu_ovf = 1; ld_alu_v = 1; tick(); idle();
        chk_flags("R5", 6'b010001);
        alu_carry = 0; alu_ovf = 0; ld_alu_c = 1; ld_alu_v = 1; tick(); idle();
        chk_flags("R5", 6'b000000);
    endtask

    task automatic t_zero();
        load_all(6'b000000);
        alu_zero = 1; ld_zero_z = 1; tick(); idle();
        chk_flags("R6", 6'b000010);
        alu_zero = 0; ld_zero_z = 1; tick(); idle();
        chk_flags("R6", 6'b000000);
    endtask

    task automatic t_clr_v();
        load_all(6'b111111);
        clr_v = 1; tick(); idle();
        chk_flags("R7", 6'b101111);
    endtask

    task automatic t_so();
        load_all(6'b000000);
        so_pin = 1;
        for (int k = 0; k < SYNC; k++) begin
            tick();
            chk_flags("R8 latency", 6'b000000);
        end
        tick();
        chk_flags("R8 forced", 6'b010000);
        // pin drops while clear is requested: synchronizer still high
        so_pin = 0; clr_v = 1;
        for (int k = 0; k < SYNC; k++) begin
            tick();
            chk_flags("R8 R10 pin over clear", 6'b010000);
        end
        tick();
        chk_flags("R7 after pin low", 6'b000000);
        idle();
    endtask

    task automatic t_priority();
        load_all(6'b000000);
        alu_carry = 1; ir_b5 = 0; db_in = 8'h00;
        ld_alu_c = 1; ld_ir_c = 1; ld_bus_c = 1; tick(); idle();
        chk_flags("R10 carry alu", 6'b000001);
        ir_b5 = 1; db_in = 8'h00; ld_ir_c = 1; ld_bus_c = 1; tick(); idle();
        chk_flags("R10 carry ir", 6'b000001);
        load_all(6'b000000);
        alu_zero = 0; db_in = 8'h0E; ld_zero_z = 1; ld_bus_izd = 1; ir_b5 = 0; ld_ir_i = 1; ld_ir_d = 1;
        tick(); idle();
        chk_flags("R10 z/i/d", 6'b000000);
        alu_ovf = 0; db_in = 8'h40; ld_alu_v = 1; ld_bus_v = 1; tick(); idle();
        chk_flags("R10 v alu over bus", 6'b000000);
        alu_ovf = 1; ld_alu_v = 1; clr_v = 1; tick(); idle();
        chk_flags("R10 v clear over alu", 6'b000000);
    endtask

    task automatic t_hold();
        load_all(6'b101010);
        db_in = 8'h55; alu_carry = 1; alu_ovf = 1; alu_zero = 1; ir_b5 = 1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk_flags("R9", 6'b101010);
        end
        alu_carry = 1; ld_alu_c = 1; tick(); idle();
        chk_flags("R9 only carry moves", 6'b101011);
    endtask

    task automatic t_bus_out();
        load_all(6'b110101);
        rd_status = 0; #1;
        chk_bus("R11 idle", 8'h00);
        rd_status = 1; #1;
        chk_bus("R11 read", 8'hE5);
        load_all(6'b001010);
        #1;
        chk_bus("R11 read", 8'h2A);
        rd_status = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; db_in = 0; alu_carry = 0; alu_ovf = 0; alu_zero = 0;
        ir_b5 = 0; so_pin = 0; rd_status = 0;
        idle();
        @(negedge clk);
        t_reset();
        t_bus_izd();
        t_bus_cvn();
        t_ir5();
        t_alu();
        t_zero();
        t_clr_v();
        t_so();
        t_priority();
        t_hold();
        t_bus_out();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule